// File: doc/BRIEF.md
# Demand DMA Request Controller

This block drives the DMA request line of a parallel-port FIFO that runs in demand mode. It watches how many FIFO entries are usable in the current transfer direction: free entries when data flows out to the peripheral, filled entries when data flows in. Once enough entries are usable, it raises the request and holds it for bursts of four acknowledged transfers. A count of consecutive transfers stops any one channel from keeping the bus too long. In the inbound direction, a 256-cycle flush timer starts when the peripheral writes a byte. If it expires, the controller raises the request even when only a few bytes are waiting.

The controller is a three-state machine:
- `ST_IDLE`: the request is low.
- `ST_BURST`: the request is high.
- `ST_COOL`: the request is low because of fairness.

The transitions are:
- `arm`: IDLE to BURST, taken when the threshold is met or the timer has expired.
- `starve`: BURST to IDLE, taken when the occupancy is zero.
- `burst_done_low`: BURST to IDLE, taken when a burst ends below the threshold.
- `burst_repeat`: BURST to BURST, taken when a burst ends with the threshold still met.
- `fair_cut`: BURST to COOL, taken when a burst ends with the consecutive count at its limit.
- `cool_release`: COOL to IDLE, taken on a cycle with no acknowledge.
- `flush`: any state to IDLE, taken on a mode-change pulse or when demand DMA is disabled.

Top module: `ddrq_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `drq` and `flush_tmo` are 0.
- R2: With `dma_en`=1 and the request low (not in cool-down), `occ_level` >= 4 raises `drq` at the next clock edge. `occ_level` of 3 or less does not raise it.
- R3: With `dma_en`=0, `drq` is 0 from the next edge onward, and neither the threshold nor the timer raises it.
- R4: Once raised, `drq` stays 1 until four `dack` strobes have been counted. The exception is a cycle with `occ_level`=0, after which `drq` falls at the next edge.
- R5: On the fourth `dack` of a burst, `drq` falls at the next edge if `occ_level` < 4 in that cycle. Otherwise it stays 1 for another burst of four.
- R6: The 32nd consecutive `dack` (the end of the eighth burst) forces `drq` low at the next edge. The consecutive count restarts from zero whenever `drq` falls.
- R7: After a fairness cut, `drq` stays 0 until one cycle has passed with `dack`=0. From the edge after that cycle, the request can re-arm, so `drq` is low for at least two cycles.
- R8: With `dir_back`=1 and `drq`=0, a `periph_wr` pulse starts the flush timer. `flush_tmo` goes to 1 at the 255th edge after the start edge.
- R9: An expired timer raises `drq` at the next edge (the 256th after the start edge), even when `occ_level` < 4. `flush_tmo` returns to 0 at that same edge.
- R10: The timer is cleared and stopped by `dir_back`=0, by `dma_en`=0, or by `drq` being raised. A cleared timer never raises `drq` without a new `periph_wr`.
- R11: A `mode_chg` pulse clears the whole mechanism: `drq` is 0 at the next edge, and the burst count, fairness count and timer are all reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en | input | 1 | Demand DMA enable |
| dir_back | input | 1 | 1 = inbound (peripheral to host), 0 = outbound |
| occ_level | input | OCC_W | Free entries (outbound) or filled entries (inbound) |
| dack | input | 1 | One-cycle strobe per completed DMA transfer |
| periph_wr | input | 1 | Pulse: peripheral side wrote a byte into the FIFO |
| mode_chg | input | 1 | Pulse: port operating mode changed |
| drq | output | 1 | DMA request |
| flush_tmo | output | 1 | Flush timer at terminal count |

## Verification
The hardest situation to reach is the fairness cut. It requires 32 acknowledged transfers with no break, and the occupancy must stay at or above the threshold at every burst boundary. Otherwise the request falls early and the consecutive count restarts. The stimulus holds the occupancy at 8 and strobes `dack` every cycle for 32 cycles, then keeps `dack` high for one extra cycle to show that the cool-down state waits for a quiet cycle. The flush path is exercised by a single write pulse followed by 256 quiet cycles, and also with a direction flip in mid-count to show that the timer clears.

// File: rtl/ddrq_pkg.sv
package ddrq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_COOL  = 2'd2
    } drq_state_e;
endpackage

// File: rtl/ddrq_level_check.sv
module ddrq_level_check #(
    parameter int OCC_W  = 5,
    parameter int THRESH = 4
) (
    input  logic [OCC_W-1:0] occ_level,
    output logic             above,
    output logic             can_service
);
    localparam logic [OCC_W-1:0] THR_V = OCC_W'(THRESH);

    always_comb begin
        above       = (occ_level >= THR_V);
        can_service = (occ_level != '0);
    end
endmodule

// File: rtl/ddrq_flush_timer.sv
module ddrq_flush_timer #(
    parameter int TMR_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic expired
);
    localparam logic [TMR_W-1:0] TERM = {TMR_W{1'b1}};

    logic [TMR_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (clr) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (run_q) begin
            if (cnt_q != TERM) cnt_q <= cnt_q + 1'b1;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end
    end

    always_comb expired = run_q && (cnt_q == TERM);

    assert_clear_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !expired);
    assert_fresh_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clr && !run_q) |=> (run_q && cnt_q == '0));
endmodule

// File: rtl/ddrq_burst_fsm.sv
module ddrq_burst_fsm
    import ddrq_pkg::*;
#(
    parameter int BURST      = 4,
    parameter int FAIR_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en,
    input  logic mode_chg,
    input  logic dack,
    input  logic above,
    input  logic can_service,
    input  logic tmo_hit,
    output logic drq,
    output logic arm
);
    localparam int BW = (BURST > 1) ? $clog2(BURST) : 1;
    localparam int FW = $clog2(FAIR_LIMIT + 1);
    localparam logic [BW-1:0] BLAST = BW'(BURST - 1);
    localparam logic [FW-1:0] FLIM  = FW'(FAIR_LIMIT);

    drq_state_e    st_q, st_d;
    logic [BW-1:0] burst_q, burst_d;
    logic [FW-1:0] fair_q, fair_d, fair_inc;

    always_comb fair_inc = fair_q + 1'b1;

    // next-state process
    always_comb begin
        st_d    = st_q;
        burst_d = burst_q;
        fair_d  = fair_q;
        if (mode_chg || !dma_en) begin
            st_d    = ST_IDLE;
            burst_d = '0;
            fair_d  = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (above || tmo_hit) begin
                        st_d    = ST_BURST;
                        burst_d = '0;
                        fair_d  = '0;
                    end
                end
                ST_BURST: begin
                    if (!can_service) begin
                        st_d    = ST_IDLE;
                        burst_d = '0;
                        fair_d  = '0;
                    end else if (dack) begin
                        if (burst_q == BLAST) begin
                            burst_d = '0;
                            if (fair_inc >= FLIM) begin
                                st_d   = ST_COOL;
                                fair_d = '0;
                            end else if (!above) begin
                                st_d   = ST_IDLE;
                                fair_d = '0;
                            end else begin
                                fair_d = fair_inc;
                            end
                        end else begin
                            burst_d = burst_q + 1'b1;
                            fair_d  = fair_inc;
                        end
                    end
                end
                ST_COOL: begin
                    if (!dack) st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            burst_q <= '0;
            fair_q  <= '0;
        end else begin
            st_q    <= st_d;
            burst_q <= burst_d;
            fair_q  <= fair_d;
        end
    end

    // output process
    always_comb begin
        drq = 1'b0;
        arm = 1'b0;
        unique case (st_q)
            ST_IDLE:  arm = dma_en && !mode_chg && (above || tmo_hit);
            ST_BURST: drq = 1'b1;
            ST_COOL:  drq = 1'b0;
            default:  drq = 1'b0;
        endcase
    end

    assert_mode_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !drq);
    assert_disable_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> !drq);
    assert_hold_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (drq && !dack && can_service && dma_en && !mode_chg) |=> drq);
    assert_fair_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fair_q < FLIM);
    assert_cool_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COOL) |=> !drq);
endmodule

// File: rtl/ddrq_ctrl.sv
module ddrq_ctrl #(
    parameter int OCC_W      = 5,
    parameter int THRESH     = 4,
    parameter int BURST      = 4,
    parameter int FAIR_LIMIT = 32,
    parameter int TMR_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_en,
    input  logic             dir_back,
    input  logic [OCC_W-1:0] occ_level,
    input  logic             dack,
    input  logic             periph_wr,
    input  logic             mode_chg,
    output logic             drq,
    output logic             flush_tmo
);
    logic above, can_service, arm, tmo_hit, tmr_clr, tmr_start;

    ddrq_level_check #(.OCC_W(OCC_W), .THRESH(THRESH)) u_level (
        .occ_level  (occ_level),
        .above      (above),
        .can_service(can_service)
    );

    always_comb begin
        tmr_clr   = mode_chg || !dma_en || !dir_back || drq || arm;
        tmr_start = periph_wr && !drq;
    end

    ddrq_flush_timer #(.TMR_W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .start  (tmr_start),
        .expired(tmo_hit)
    );

    ddrq_burst_fsm #(.BURST(BURST), .FAIR_LIMIT(FAIR_LIMIT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_en     (dma_en),
        .mode_chg   (mode_chg),
        .dack       (dack),
        .above      (above),
        .can_service(can_service),
        .tmo_hit    (tmo_hit),
        .drq        (drq),
        .arm        (arm)
    );

    always_comb flush_tmo = tmo_hit;

    assert_rise_needs_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drq) |-> $past(dma_en && (occ_level >= OCC_W'(THRESH) || tmo_hit)));
endmodule

// File: tb/test_ddrq_ctrl.sv
module test_ddrq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_en = 1'b0, dir_back = 1'b0, dack = 1'b0, periph_wr = 1'b0, mode_chg = 1'b0;
    logic [4:0] occ_level = '0;
    logic       drq, flush_tmo;

    int n_tests = 0, n_fail = 0;
    bit q_drq[$];
    bit q_tmo[$];
    string q_tag[$];
    string cur_tag = "R1";

    // reference model state
    int m_st = 0, m_b = 0, m_f = 0, m_t = 0;
    bit m_run = 0;

    always #10 clk = ~clk;

    ddrq_ctrl i_ddrq_ctrl (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dir_back(dir_back),
        .occ_level(occ_level), .dack(dack), .periph_wr(periph_wr),
        .mode_chg(mode_chg), .drq(drq), .flush_tmo(flush_tmo)
    );

    task automatic chk(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // driver: advance model with current inputs, queue expectation, step one clock
    task automatic tick();
        int  st_n, b_n, f_n, t_n;
        bit  run_n, hit, arm;
        hit   = m_run && (m_t == 255);
        arm   = (m_st == 0) && dma_en && !mode_chg && (occ_level >= 4 || hit);
        st_n = m_st; b_n = m_b; f_n = m_f;
        if (mode_chg || !dma_en) begin
            st_n = 0; b_n = 0; f_n = 0;
        end else if (m_st == 0) begin
            if (occ_level >= 4 || hit) begin st_n = 1; b_n = 0; f_n = 0; end
        end else if (m_st == 1) begin
            if (occ_level == 0) begin st_n = 0; b_n = 0; f_n = 0; end
            else if (dack) begin
                if (m_b == 3) begin
                    b_n = 0;
                    if (m_f + 1 >= 32) begin st_n = 2; f_n = 0; end
                    else if (occ_level < 4) begin st_n = 0; f_n = 0; end
                    else f_n = m_f + 1;
                end else begin b_n = m_b + 1; f_n = m_f + 1; end
            end
        end else begin
            if (!dack) st_n = 0;
        end
        run_n = m_run; t_n = m_t;
        if (mode_chg || !dma_en || !dir_back || m_st == 1 || arm) begin
            run_n = 0; t_n = 0;
        end else if (m_run) begin
            if (m_t != 255) t_n = m_t + 1;
        end else if (periph_wr && m_st != 1) begin
            run_n = 1; t_n = 0;
        end
        m_st = st_n; m_b = b_n; m_f = f_n; m_run = run_n; m_t = t_n;
        q_drq.push_back(m_st == 1);
        q_tmo.push_back(m_run && m_t == 255);
        q_tag.push_back(cur_tag);
        @(negedge clk);
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #5;
        if (q_drq.size() > 0) begin
            bit    ed, et;
            string tg;
            ed = q_drq.pop_front();
            et = q_tmo.pop_front();
            tg = q_tag.pop_front();
            chk({tg, " drq"}, drq, ed);
            chk({tg, " flush_tmo"}, flush_tmo, et);
        end
    end

    initial begin
        #(20 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset drq", drq, 1'b0);
        chk("R1 reset tmo", flush_tmo, 1'b0);
        rst_n = 1'b1;
        cur_tag = "R1"; tick();

        // R3: disabled, threshold met, no request
        cur_tag = "R3"; occ_level = 5'd8;
        repeat (3) tick();
        chk("R3 disabled stays low", drq, 1'b0);

        // R2: below threshold, then at threshold (outbound)
        cur_tag = "R2"; dma_en = 1'b1; occ_level = 5'd3;
        repeat (3) tick();
        chk("R2 occ=3 no request", drq, 1'b0);
        occ_level = 5'd4; tick();
        chk("R2 occ=4 raises", drq, 1'b1);

        // R4/R5: hold through burst while occupancy falls, drop at end
        cur_tag = "R4"; occ_level = 5'd2;
        repeat (2) tick();
        chk("R4 held below threshold", drq, 1'b1);
        dack = 1; repeat (3) tick();
        chk("R4 held after 3 dack", drq, 1'b1);
        cur_tag = "R5"; tick(); dack = 0;
        chk("R5 drop after 4th dack below thr", drq, 1'b0);

        // R5: repeat burst while above
        occ_level = 5'd6; tick();
        dack = 1; repeat (4) tick(); dack = 0;
        chk("R5 rearm burst when above", drq, 1'b1);
        // R4: starve mid-burst
        cur_tag = "R4"; occ_level = 5'd0; tick();
        chk("R4 starve drops", drq, 1'b0);

        // R6/R7: fairness after 32 consecutive transfers
        cur_tag = "R6"; occ_level = 5'd8; tick();
        dack = 1; repeat (31) tick();
        chk("R6 still high after 31", drq, 1'b1);
        tick();
        chk("R6 fairness cut", drq, 1'b0);
        cur_tag = "R7"; tick();
        chk("R7 cool holds with dack", drq, 1'b0);
        dack = 0; tick();
        chk("R7 release cycle low", drq, 1'b0);
        tick();
        chk("R7 re-arm", drq, 1'b1);

        // R11: mode change mid burst
        cur_tag = "R11"; mode_chg = 1; tick(); mode_chg = 0;
        chk("R11 mode change clears", drq, 1'b0);
        occ_level = 5'd1; repeat (2) tick();

        // R8/R9: inbound flush timer
        cur_tag = "R8"; dir_back = 1; periph_wr = 1; tick(); periph_wr = 0;
        begin
            int first_hi = 0;
            for (int k = 1; k <= 260; k++) begin
                cur_tag = (k >= 255) ? "R9" : "R8";
                tick();
                if (k == 255) chk("R8 flush_tmo at 255", flush_tmo, 1'b1);
                if (first_hi == 0 && drq) first_hi = k;
            end
            n_tests++;
            if (first_hi != 256) begin
                n_fail++;
                $display("FAIL R9 timer request edge actual=%0d expected=256", first_hi);
            end
        end
        cur_tag = "R4"; dack = 1; repeat (4) tick(); dack = 0;
        chk("R5 drop after flush burst", drq, 1'b0);

        // R10: direction flip clears running timer
        cur_tag = "R10"; periph_wr = 1; tick(); periph_wr = 0;
        repeat (100) tick();
        dir_back = 0; tick(); dir_back = 1;
        repeat (300) tick();
        chk("R10 cleared timer idle", drq, 1'b0);
        chk("R10 cleared timer tmo", flush_tmo, 1'b0);
        // R10: disable clears timer
        periph_wr = 1; tick(); periph_wr = 0;
        repeat (50) tick();
        dma_en = 0; tick(); dma_en = 1;
        repeat (300) tick();
        chk("R10 disable cleared timer", drq, 1'b0);

        // R11: mode change clears running timer
        cur_tag = "R11"; periph_wr = 1; tick(); periph_wr = 0;
        repeat (200) tick();
        mode_chg = 1; tick(); mode_chg = 0;
        repeat (100) tick();
        chk("R11 timer cleared by mode", drq, 1'b0);

        @(negedge clk); @(negedge clk);
        finish_run();
    end
endmodule